// File: doc/BRIEF.md
# HDLC Transmit Preamble and Flag Sequencer

This block builds the serial transmit line around each HDLC frame. Between frames it sends idle flags. The flag is 0x7E, sent least significant bit first. When a frame is requested, it first sends an optional preamble, chosen by pattern and length. It then sends an opening flag. Next it passes the frame body, one bit per bit strobe; the body is already bit-stuffed and already carries its check sequence. After the body it sends a full closing flag and goes back to idle flags.

Two modem-control options can be switched on. With clear-to-send gating, the frame does not start until CTS is high, and the frame is abandoned at once if CTS drops while the frame is being sent. With request-to-send control, RTS covers the whole transmission.

The line advances only on clock cycles where the one-cycle bit strobe is high. The body source presents a bit and an end marker. It moves on to its next bit after each cycle in which `body_take` is high. It holds `frame_req` high until it sees the completion pulse or the abort pulse.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset, `txd` is 1 and `rts_out`, `body_take`, `done_pulse` and `abort_pulse` are all 0.
- R2: With no frame in progress, the line repeats the flag 0x7E least significant bit first. That is the 8-bit sequence 0,1,1,1,1,1,1,0, one bit per strobe.
- R3: With `cfg_share_zero` set, idle flags share their zero bit, so the idle line repeats the 7-bit sequence 0,1,1,1,1,1,1. The opening flag and the closing flag are always full 8-bit flags.
- R4: A frame starts only at an idle flag boundary. The first bit of the preamble, or of the opening flag, goes out on the strobe that starts the frame. Preamble pattern codes in `cfg_pre_pat`: 1 sends all zeros, 2 sends all ones, 3 sends repeated flags, 4 sends alternating bits starting with 1, and 5 sends alternating bits starting with 0.
- R5: Preamble length codes in `cfg_pre_len` are 0=8, 1=16, 2=32 and 3=64 bits. A preamble is sent before every frame. Pattern codes 0, 6 and 7 send no preamble, and the length code is then ignored.
- R6: After the full opening flag, each strobe sends `body_bit` and raises `body_take` in that same cycle. The body ends with the bit that has `body_last` set.
- R7: After the last body bit, the block sends a full closing flag. On the clock after that flag's final strobe, `done_pulse` is high for one cycle. The line then returns to idle flags.
- R8: With `cfg_auto_cts` set, a requested frame does not start while `cts_in` is 0, and idle flags continue.
- R9: With `cfg_auto_cts` set, if `cts_in` is 0 during a frame, `abort_pulse` rises on the next clock and no further body bits are taken. The line resumes idle flags from the next strobe after that.
- R10: `rts_out` is high exactly when `cfg_auto_rts` is set and either a frame is in progress or `frame_req` is high.
- R11: `txd` changes only on the clock after a cycle with `bit_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle bit strobe |
| frame_req | input | 1 | A frame is waiting; held until done or abort |
| body_bit | input | 1 | Current stuffed body bit |
| body_last | input | 1 | Current body bit is the last one |
| body_take | output | 1 | The body bit is consumed on this strobe |
| cfg_pre_pat | input | 3 | Preamble pattern code |
| cfg_pre_len | input | 2 | Preamble length code |
| cfg_share_zero | input | 1 | Idle flags share their zero bit |
| cfg_auto_cts | input | 1 | Gate start and abort on CTS |
| cfg_auto_rts | input | 1 | Drive RTS around transmission |
| cts_in | input | 1 | Clear to send |
| rts_out | output | 1 | Request to send |
| txd | output | 1 | Serial transmit bit |
| done_pulse | output | 1 | Frame completed |
| abort_pulse | output | 1 | Frame abandoned on CTS loss |

## Verification
The checks assume the following about the inputs.
- `bit_en` is never high in two back-to-back cycles.
- The configuration stays stable while a frame is in progress.
- `cfg_share_zero` changes only while a frame is busy.
- `frame_req` is dropped within one strobe period after completion or abort.

The stimulus keeps to these rules. It produces a strobe every fourth clock. It changes the pattern, length and gating settings only between frames, and it changes the shared-zero setting only after the first body bit has been taken. It releases the request on the clock after it sees either result pulse.

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int BASE_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       frame_req,
  input  logic       body_bit,
  input  logic       body_last,
  output logic       body_take,
  input  logic [2:0] cfg_pre_pat,
  input  logic [1:0] cfg_pre_len,
  input  logic       cfg_share_zero,
  input  logic       cfg_auto_cts,
  input  logic       cfg_auto_rts,
  input  logic       cts_in,
  output logic       rts_out,
  output logic       txd,
  output logic       done_pulse,
  output logic       abort_pulse
);
  localparam int CW = $clog2(BASE_LEN * 8);
  localparam logic [7:0] FLAG = 8'h7E;
  localparam logic [CW-1:0] FLAG_END = CW'(7);
  localparam logic [CW-1:0] SHARE_END = CW'(6);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_OPEN, S_BODY, S_CLOSE} st_t;

  st_t state, eff_st;
  logic [CW-1:0] cnt, eff_cnt, pre_last;
  logic pre_bit, out_bit;

  wire has_pre   = (cfg_pre_pat >= 3'd1) && (cfg_pre_pat <= 3'd5);
  wire busy      = (state != S_IDLE);
  wire abort_now = busy && cfg_auto_cts && !cts_in;
  wire go        = frame_req && (!cfg_auto_cts || cts_in);
  wire launch    = (state == S_IDLE) && (cnt == '0) && go;

  assign pre_last  = CW'((BASE_LEN << cfg_pre_len) - 1);
  assign body_take = bit_en && (eff_st == S_BODY) && !abort_now;
  assign rts_out   = cfg_auto_rts && (busy || frame_req);

  always_comb begin
    eff_st  = state;
    eff_cnt = cnt;
    if (launch) begin
      eff_st  = has_pre ? S_PRE : S_OPEN;
      eff_cnt = '0;
    end
  end

  always_comb begin
    case (cfg_pre_pat)
      3'd1:    pre_bit = 1'b0;
      3'd2:    pre_bit = 1'b1;
      3'd3:    pre_bit = FLAG[eff_cnt[2:0]];
      3'd4:    pre_bit = ~eff_cnt[0];
      3'd5:    pre_bit = eff_cnt[0];
      default: pre_bit = 1'b1;
    endcase
  end

  always_comb begin
    case (eff_st)
      S_PRE:   out_bit = pre_bit;
      S_BODY:  out_bit = body_bit;
      default: out_bit = FLAG[eff_cnt[2:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      txd         <= 1'b1;
      done_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      done_pulse  <= 1'b0;
      abort_pulse <= 1'b0;
      if (abort_now) begin
        state       <= S_IDLE;
        cnt         <= '0;
        abort_pulse <= 1'b1;
      end else if (bit_en) begin
        txd   <= out_bit;
        state <= eff_st;
        cnt   <= eff_cnt + 1'b1;
        case (eff_st)
          S_IDLE:
            if (eff_cnt == FLAG_END || (cfg_share_zero && eff_cnt == SHARE_END))
              cnt <= '0;
          S_PRE:
            if (eff_cnt == pre_last) begin
              state <= S_OPEN;
              cnt   <= '0;
            end
          S_OPEN:
            if (eff_cnt == FLAG_END) begin
              state <= S_BODY;
              cnt   <= '0;
            end
          S_BODY: begin
            cnt <= '0;
            if (body_last) state <= S_CLOSE;
          end
          S_CLOSE:
            if (eff_cnt == FLAG_END) begin
              state      <= S_IDLE;
              cnt        <= '0;
              done_pulse <= 1'b1;
            end
          default: begin
            state <= S_IDLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic body_take,
  input logic txd,
  input logic done_pulse,
  input logic abort_pulse,
  input logic cfg_auto_cts,
  input logic cfg_auto_rts,
  input logic cts_in,
  input logic rts_out
);
  a_r11_txd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> $stable(txd));

  a_r6_take_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    body_take |-> bit_en);

  a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> $past(bit_en));

  a_r9_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> $past(cfg_auto_cts && !cts_in));

  a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_pulse && abort_pulse));

  a_r10_rts_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_auto_rts |-> !rts_out);
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .body_take(body_take), .txd(txd),
  .done_pulse(done_pulse), .abort_pulse(abort_pulse), .cfg_auto_cts(cfg_auto_cts),
  .cfg_auto_rts(cfg_auto_rts), .cts_in(cts_in), .rts_out(rts_out)
);

// File: tb/tb_hdlc_tx_framer.sv
`timescale 1ns/1ps
module tb_hdlc_tx_framer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, bit_en = 1'b0, frame_req = 1'b0, body_bit = 1'b0, body_last = 1'b0;
  logic [2:0] cfg_pre_pat = 3'd0;
  logic [1:0] cfg_pre_len = 2'd0;
  logic cfg_share_zero = 1'b0, cfg_auto_cts = 1'b0, cfg_auto_rts = 1'b0, cts_in = 1'b1;
  logic body_take, rts_out, txd, done_pulse, abort_pulse;

  hdlc_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_req(frame_req),
    .body_bit(body_bit), .body_last(body_last), .body_take(body_take),
    .cfg_pre_pat(cfg_pre_pat), .cfg_pre_len(cfg_pre_len), .cfg_share_zero(cfg_share_zero),
    .cfg_auto_cts(cfg_auto_cts), .cfg_auto_rts(cfg_auto_rts), .cts_in(cts_in),
    .rts_out(rts_out), .txd(txd), .done_pulse(done_pulse), .abort_pulse(abort_pulse)
  );

  int errors = 0, checks = 0;
  bit started = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  typedef enum {M_IDLE, M_FRAME, M_BODY, M_CLOSE} mph_t;
  mph_t mph = M_IDLE;
  bit mq[$];
  bit m_txd = 1, m_done = 0, m_abort = 0;

  function automatic void push_flag(input int n);
    for (int i = 0; i < n; i++) mq.push_back(i != 0 && i != 7);
  endfunction

  function automatic void push_preamble();
    int len;
    len = 8 * (1 << cfg_pre_len);
    if (cfg_pre_pat < 1 || cfg_pre_pat > 5) return;
    for (int i = 0; i < len; i++) begin
      case (cfg_pre_pat)
        3'd1: mq.push_back(0);
        3'd2: mq.push_back(1);
        3'd3: mq.push_back((i % 8) != 0 && (i % 8) != 7);
        3'd4: mq.push_back((i % 2) == 0);
        default: mq.push_back((i % 2) == 1);
      endcase
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = M_IDLE; mq.delete(); m_txd = 1; m_done = 0; m_abort = 0;
    end else begin
      m_done = 0; m_abort = 0;
      if (mph != M_IDLE && cfg_auto_cts && !cts_in) begin
        mq.delete(); mph = M_IDLE; m_abort = 1;
      end else if (bit_en) begin
        case (mph)
          M_IDLE: begin
            if (mq.size() == 0) begin
              if (frame_req && (!cfg_auto_cts || cts_in)) begin
                push_preamble(); push_flag(8); mph = M_FRAME;
              end else push_flag(cfg_share_zero ? 7 : 8);
            end
            m_txd = mq.pop_front();
          end
          M_FRAME: begin
            m_txd = mq.pop_front();
            if (mq.size() == 0) mph = M_BODY;
          end
          M_BODY: begin
            m_txd = body_bit;
            if (body_last) begin push_flag(8); mph = M_CLOSE; end
          end
          default: begin
            m_txd = mq.pop_front();
            if (mq.size() == 0) begin mph = M_IDLE; m_done = 1; end
          end
        endcase
      end
    end
  end

  bit prev_en = 0;
  logic prev_txd = 1'b1;
  bit take_seen = 0;

  always @(negedge clk) begin
    bit exp_take, exp_rts;
    string tag;
    take_seen = body_take;
    if (rst_n && started) begin
      exp_take = bit_en && mph == M_BODY && !(cfg_auto_cts && !cts_in);
      exp_rts  = cfg_auto_rts && (mph != M_IDLE || frame_req);
      case (mph)
        M_IDLE:  tag = "R2 R3 R8 txd";
        M_FRAME: tag = "R4 R5 txd";
        M_BODY:  tag = "R6 txd";
        default: tag = "R7 txd";
      endcase
      chk(txd === m_txd, tag, txd, m_txd);
      chk(body_take === exp_take, "R6 body_take", body_take, exp_take);
      chk(done_pulse === m_done, "R7 done_pulse", done_pulse, m_done);
      chk(abort_pulse === m_abort, "R9 abort_pulse", abort_pulse, m_abort);
      chk(rts_out === exp_rts, "R10 rts_out", rts_out, exp_rts);
      if (!prev_en) chk(txd === prev_txd, "R11 txd moved without strobe", txd, prev_txd);
    end
    prev_en = bit_en;
    prev_txd = txd;
  end

  // strobe generator and body feeder
  int div = 0;
  bit body_q[$];
  always @(posedge clk) begin
    #1;
    div = (div + 1) % 4;
    bit_en = rst_n && (div == 0);
    if (take_seen && body_q.size() > 0) void'(body_q.pop_front());
    take_seen = 0;
    body_bit  = (body_q.size() > 0) ? body_q[0] : 1'b0;
    body_last = (body_q.size() == 1);
  end

  task automatic run_frame(input int pat, input int len, input bit share, input bit acts,
                           input bit arts, input int nbits, input int seed,
                           input int abort_after, input int cts_wait);
    int takes = 0, wait_takes = 0;
    bit fin = 0, got_done = 0, got_abort = 0, shared_set = 0;
    @(posedge clk); #1;
    cfg_pre_pat = 3'(pat); cfg_pre_len = 2'(len);
    cfg_auto_cts = acts; cfg_auto_rts = arts;
    for (int i = 0; i < nbits; i++) body_q.push_back(((i * 7 + seed) % 3) == 0);
    if (cts_wait > 0) cts_in = 0;
    frame_req = 1;
    if (cts_wait > 0) begin
      for (int c = 0; c < cts_wait; c++) begin
        @(negedge clk);
        if (body_take) wait_takes++;
      end
      chk(wait_takes == 0, "R8 no body taken while CTS low", wait_takes, 0);
      chk(rts_out == arts, "R10 RTS during CTS wait", rts_out, arts);
      @(posedge clk); #1 cts_in = 1;
    end
    while (!fin) begin
      @(negedge clk);
      if (body_take) begin
        takes++;
        if (!shared_set) begin shared_set = 1; cfg_share_zero = share; end
      end
      if (done_pulse) begin fin = 1; got_done = 1; end
      else if (abort_pulse) begin fin = 1; got_abort = 1; end
      else if (abort_after > 0 && takes == abort_after && cts_in) begin
        @(posedge clk); #1 cts_in = 0;
      end
    end
    @(posedge clk); #1;
    frame_req = 0; cts_in = 1; body_q.delete();
    if (abort_after == 0) begin
      chk(got_done, "R7 frame completed", got_done, 1);
      chk(takes == nbits, "R6 body bits taken", takes, nbits);
    end else begin
      chk(got_abort, "R9 frame aborted", got_abort, 1);
      chk(takes == abort_after, "R9 body bits before abort", takes, abort_after);
    end
    repeat (60) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(txd === 1'b1, "R1 reset txd", txd, 1);
    chk(rts_out === 1'b0, "R1 reset rts", rts_out, 0);
    chk(body_take === 1'b0, "R1 reset take", body_take, 0);
    chk(done_pulse === 1'b0 && abort_pulse === 1'b0, "R1 reset pulses", done_pulse, 0);
    @(posedge clk); #1 rst_n = 1;
    started = 1;
    repeat (50) @(posedge clk);
    run_frame(0, 2, 0, 0, 0, 12, 1, 0, 0);
    run_frame(1, 0, 1, 0, 0, 9, 2, 0, 0);
    run_frame(2, 1, 1, 0, 0, 15, 3, 0, 0);
    run_frame(3, 2, 0, 0, 0, 10, 4, 0, 0);
    run_frame(4, 3, 0, 0, 0, 20, 5, 0, 0);
    run_frame(5, 0, 1, 0, 0, 11, 6, 0, 0);
    run_frame(6, 1, 0, 0, 0, 8, 7, 0, 0);
    run_frame(4, 0, 0, 1, 1, 14, 8, 0, 200);
    run_frame(3, 0, 1, 1, 1, 30, 9, 5, 0);
    run_frame(2, 0, 0, 1, 1, 1, 10, 0, 0);
    run_frame(0, 0, 0, 0, 1, 6, 11, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule